// File: doc/BRIEF.md
# PIO Audio Sample Byte Sequencer

This block lets a host move audio samples one byte at a time through a narrow register port. The port has an 8-bit data bus and a 2-bit address. The data address is shared by both directions. A host write to it adds the next byte to the outgoing playback sample. A host read from it returns the next byte of the most recent captured sample. Two separate byte pointers track how far each direction has got. The pointers saturate; they never wrap.

Two format bits set the sample size:

| Stereo | 16-bit | Bytes per sample |
|---|---|---|
| 0 | 0 | 1 |
| 0 | 1 | 2 |
| 1 | 0 | 2 |
| 1 | 1 | 4 |

Both directions lay samples out in a 32-bit word.

The converter side connects through two valid/ready streams.

- **Capture stream (inbound).** `cap_ready_o` is high whenever initialisation has ended. A captured word is taken on any cycle where `cap_valid_i` and `cap_ready_o` are both high, so the converter side is never held off after initialisation.
- **Playback stream (outbound).** It offers a complete word with `pb_valid_o`. The word and the valid flag hold steady until the converter side raises `pb_ready_i`.

After reset the block is initialising. In that state, host reads return a fixed fill byte and host writes are dropped. The state ends when `init_done_i` is seen high.

Top module: `pio_sample_sequencer`

## Requirements
- R1: Only host address 3 is the data port. Writes there feed playback and reads there return capture bytes. An access to any other address changes no pointer or word, and `host_rdata_o` is 0 whenever a read of address 3 is not in progress.
- R2: Synchronous active-high `rst` sets `init_o`. `init_o` clears on the first clock edge with `init_done_i` high and stays clear until the next reset. While `init_o` is high, a read of address 3 returns 8'h80 and does not move the capture pointer.
- R3: While `init_o` is high, host writes to address 3 are ignored: `pb_next_o` stays 0 and `pb_valid_o` stays low.
- R4: The sample byte count is 1 for mono 8-bit, 2 for mono 16-bit, 2 for stereo 8-bit and 4 for stereo 16-bit. Byte k maps to a lane of the 32-bit word as follows:
  - mono 8-bit: byte 0 is bits 7:0.
  - mono 16-bit: byte 0 is bits 7:0 and byte 1 is bits 15:8.
  - stereo 8-bit: byte 0 (left) is bits 7:0 and byte 1 (right) is bits 23:16.
  - stereo 16-bit: byte k is bits 8k+7:8k, in the order left low, left high, right low, right high.
- R5: Each read of address 3 outside initialisation returns the byte at the capture pointer and then advances the pointer. At the last byte the pointer stays put, and further reads repeat that byte.
- R6: A capture handshake (`cap_valid_i` and `cap_ready_o`, where `cap_ready_o` is the inverse of `init_o`) stores the word and sets the capture pointer to 0 on the next cycle. This takes priority over a read in the same cycle, and that read still returns the old byte.
- R7: Each write to address 3 outside initialisation stores the byte in its lane and advances the playback pointer. The cycle after the final byte is written, `pb_valid_o` is high with the full word. Lanes the format does not use read as 0.
- R8: While `pb_valid_o` is high, host writes are dropped. `pb_valid_o` and `pb_data_o` hold unchanged until `pb_ready_i` is high.
- R9: A playback handshake (`pb_valid_o` and `pb_ready_i`) clears `pb_valid_o`, returns the playback pointer to 0 and clears the word on the next cycle.
- R10: `cap_next_o` shows the index of the next capture byte to be read, and `pb_next_o` the index of the next playback byte to be written. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Ends initialisation |
| host_addr_i | input | 2 | Host register address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid while the read strobe is high |
| fmt_stereo_i | input | 1 | 1 = stereo, 0 = mono |
| fmt_wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| cap_valid_i | input | 1 | Captured word offered |
| cap_ready_o | output | 1 | Captured word accepted (high once initialised) |
| cap_data_i | input | 32 | Captured word |
| pb_valid_o | output | 1 | Playback word complete |
| pb_ready_i | input | 1 | Converter side takes the playback word |
| pb_data_o | output | 32 | Playback word |
| cap_next_o | output | 2 | Next capture byte index |
| pb_next_o | output | 2 | Next playback byte index |
| init_o | output | 1 | Initialisation in progress |

## Verification
The bench builds the block with its default 8-bit byte and four-lane word. This brings all four format combinations within reach, including the stereo 8-bit case, where the lanes are not adjacent. A vector table runs capture reads past the end of the sample in every format, which exercises saturation at byte indices 0, 1 and 3. Directed tests then cover the following:

- initialisation and its fill byte;
- a capture handshake in the same cycle as a read;
- extra playback writes while the word waits for back-pressure;
- zero-filled unused lanes after each playback handshake.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef struct packed {
    logic stereo;
    logic wide;
  } fmt_t;

  // Index of the final byte of a sample for the given format.
  function automatic int unsigned last_index(fmt_t f);
    case ({f.stereo, f.wide})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 1;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/seq_byte_ptr.sv
module seq_byte_ptr #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  logic [IDX_W-1:0] idx_q;

  assign at_last = (idx_q >= last);
  assign idx     = idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
    end else if (step && !at_last) begin
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/seq_capture_path.sv
module seq_capture_path
  import pio_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_t              fmt,
  input  logic              accept,
  input  logic [WORD_W-1:0] word_in,
  input  logic              rd_step,
  output logic [BYTE_W-1:0] byte_out,
  output logic [IDX_W-1:0]  idx
);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  last;
  logic [IDX_W-1:0]  lane;
  logic              at_last_unused;

  assign last = IDX_W'(last_index(fmt));

  // Stereo 8-bit puts the right channel in the upper half of the word.
  assign lane = (fmt.stereo && !fmt.wide) ? IDX_W'(idx << 1) : idx;

  seq_byte_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .step    (rd_step),
    .last    (last),
    .idx     (idx),
    .at_last (at_last_unused)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= word_in;
    end
  end

  assign byte_out = word_q[lane*BYTE_W +: BYTE_W];

endmodule

// File: rtl/seq_playback_path.sv
module seq_playback_path
  import pio_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_t              fmt,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  idx
);

  logic              valid_q;
  logic [IDX_W-1:0]  last;
  logic [IDX_W-1:0]  lane;
  logic              at_last;
  logic              take;
  logic              accept_wr;

  assign last      = IDX_W'(last_index(fmt));
  assign lane      = (fmt.stereo && !fmt.wide) ? IDX_W'(idx << 1) : idx;
  assign take      = valid_q && ready;
  assign accept_wr = wr_en && !valid_q;

  seq_byte_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .clr     (take),
    .step    (accept_wr),
    .last    (last),
    .idx     (idx),
    .at_last (at_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst || take) begin
        lane_q <= '0;
      end else if (accept_wr && (lane == IDX_W'(g))) begin
        lane_q <= wdata;
      end
    end

    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst || take) begin
      valid_q <= 1'b0;
    end else if (accept_wr && at_last) begin
      valid_q <= 1'b1;
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/pio_sample_sequencer.sv
module pio_sample_sequencer
  import pio_seq_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          LANES     = 4,
  parameter int          ADDR_W    = 2,
  parameter int          DATA_ADDR = 3,
  parameter logic [7:0]  INIT_FILL = 8'h80,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              fmt_stereo_i,
  input  logic              fmt_wide_i,
  input  logic              cap_valid_i,
  output logic              cap_ready_o,
  input  logic [WORD_W-1:0] cap_data_i,
  output logic              pb_valid_o,
  input  logic              pb_ready_i,
  output logic [WORD_W-1:0] pb_data_o,
  output logic [IDX_W-1:0]  cap_next_o,
  output logic [IDX_W-1:0]  pb_next_o,
  output logic              init_o
);

  logic              init_q;
  logic              is_data;
  logic              rd_step;
  logic              wr_en;
  logic              cap_accept;
  logic [BYTE_W-1:0] cap_byte;
  fmt_t              fmt;

  assign fmt.stereo = fmt_stereo_i;
  assign fmt.wide   = fmt_wide_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b1;
    end else if (init_done_i) begin
      init_q <= 1'b0;
    end
  end

  assign init_o      = init_q;
  assign is_data     = (host_addr_i == ADDR_W'(DATA_ADDR));
  assign rd_step     = host_rd_i && is_data && !init_q;
  assign wr_en       = host_wr_i && is_data && !init_q;
  assign cap_ready_o = !init_q;
  assign cap_accept  = cap_valid_i && cap_ready_o;

  seq_capture_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .fmt      (fmt),
    .accept   (cap_accept),
    .word_in  (cap_data_i),
    .rd_step  (rd_step),
    .byte_out (cap_byte),
    .idx      (cap_next_o)
  );

  seq_playback_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pb (
    .clk   (clk),
    .rst   (rst),
    .fmt   (fmt),
    .wr_en (wr_en),
    .wdata (host_wdata_i),
    .ready (pb_ready_i),
    .valid (pb_valid_o),
    .word  (pb_data_o),
    .idx   (pb_next_o)
  );

  always_comb begin
    host_rdata_o = '0;
    if (host_rd_i && is_data) begin
      host_rdata_o = init_q ? BYTE_W'(INIT_FILL) : cap_byte;
    end
  end

endmodule

// File: rtl/pio_sample_sequencer_chk.sv
module pio_sample_sequencer_chk #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int ADDR_W = 2,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              init_done_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [BYTE_W-1:0] host_wdata_i,
  input logic [BYTE_W-1:0] host_rdata_o,
  input logic              fmt_stereo_i,
  input logic              fmt_wide_i,
  input logic              cap_valid_i,
  input logic              cap_ready_o,
  input logic [WORD_W-1:0] cap_data_i,
  input logic              pb_valid_o,
  input logic              pb_ready_i,
  input logic [WORD_W-1:0] pb_data_o,
  input logic [IDX_W-1:0]  cap_next_o,
  input logic [IDX_W-1:0]  pb_next_o,
  input logic              init_o
);

  AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_addr_i != ADDR_W'(3)) |-> host_rdata_o == '0); // R1

  AST_INIT_FILL: assert property (@(posedge clk) disable iff (rst)
    (init_o && host_rd_i && host_addr_i == ADDR_W'(3)) |-> host_rdata_o == BYTE_W'(8'h80)); // R2

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !init_o |=> !init_o); // R2

  AST_INIT_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
    (init_o && host_wr_i) |=> ($stable(pb_next_o) && !pb_valid_o)); // R3

  AST_CAP_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_addr_i == ADDR_W'(3) && !init_o && !cap_valid_i
     && cap_next_o == IDX_W'(LANES - 1)) |=> cap_next_o == IDX_W'(LANES - 1)); // R5

  AST_CAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_i && cap_ready_o) |=> cap_next_o == '0); // R6

  AST_PB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pb_valid_o && !pb_ready_i) |=> (pb_valid_o && $stable(pb_data_o))); // R8

  AST_PB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pb_valid_o && pb_ready_i) |=> (!pb_valid_o && pb_next_o == '0)); // R9

endmodule

bind pio_sample_sequencer pio_sample_sequencer_chk #(
  .BYTE_W(BYTE_W), .LANES(LANES), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_pio_sample_sequencer.sv
`timescale 1ns/100ps
module tb_pio_sample_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_done_i = 1'b0;
  logic [1:0]  host_addr_i = 2'd0;
  logic        host_wr_i = 1'b0;
  logic        host_rd_i = 1'b0;
  logic [7:0]  host_wdata_i = 8'd0;
  logic [7:0]  host_rdata_o;
  logic        fmt_stereo_i = 1'b0;
  logic        fmt_wide_i = 1'b0;
  logic        cap_valid_i = 1'b0;
  logic        cap_ready_o;
  logic [31:0] cap_data_i = 32'd0;
  logic        pb_valid_o;
  logic        pb_ready_i = 1'b0;
  logic [31:0] pb_data_o;
  logic [1:0]  cap_next_o;
  logic [1:0]  pb_next_o;
  logic        init_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pio_sample_sequencer dut (.*);

  // {stereo, wide, word, expected bytes of five successive reads}
  localparam logic [73:0] CAP_VEC [6] = '{
    {1'b0, 1'b0, 32'hA4B3C2D1, 40'hD1D1D1D1D1},
    {1'b0, 1'b1, 32'hA4B3C2D1, 40'hD1C2C2C2C2},
    {1'b1, 1'b0, 32'hA4B3C2D1, 40'hD1B3B3B3B3},
    {1'b1, 1'b1, 32'hA4B3C2D1, 40'hD1C2B3A4A4},
    {1'b1, 1'b1, 32'h11223344, 40'h4433221111},
    {1'b0, 1'b1, 32'h11223344, 40'h4433333333}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic [1:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    host_addr_i = a;
    host_rd_i = 1'b1;
    #1 chk(req, {24'd0, host_rdata_o}, {24'd0, exp});
    @(posedge clk);
    #1 host_rd_i = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr_i = a;
    host_wdata_i = d;
    host_wr_i = 1'b1;
    @(posedge clk);
    #1 host_wr_i = 1'b0;
  endtask

  task automatic push_cap(input logic [31:0] w);
    @(negedge clk);
    cap_data_i = w;
    cap_valid_i = 1'b1;
    @(posedge clk);
    #1 cap_valid_i = 1'b0;
  endtask

  task automatic pb_take();
    @(negedge clk);
    pb_ready_i = 1'b1;
    @(posedge clk);
    #1 pb_ready_i = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    settle();
    chk("R2 init after reset", {31'd0, init_o}, 32'd1);
    chk("R10 cap_next reset", {30'd0, cap_next_o}, 32'd0);
    chk("R10 pb_next reset", {30'd0, pb_next_o}, 32'd0);
    chk("R9 pb_valid reset", {31'd0, pb_valid_o}, 32'd0);
    chk("R6 cap_ready low in init", {31'd0, cap_ready_o}, 32'd0);

    host_read(2'd3, "R2 init fill byte", 8'h80);
    settle();
    chk("R2 init read keeps pointer", {30'd0, cap_next_o}, 32'd0);

    fmt_stereo_i = 1'b1;
    fmt_wide_i = 1'b1;
    for (int i = 0; i < 4; i++) host_write(2'd3, 8'hE0 + 8'(i));
    settle();
    chk("R3 init write pointer", {30'd0, pb_next_o}, 32'd0);
    chk("R3 init write valid", {31'd0, pb_valid_o}, 32'd0);

    @(negedge clk);
    init_done_i = 1'b1;
    @(posedge clk);
    #1 init_done_i = 1'b0;
    settle();
    chk("R2 init ended", {31'd0, init_o}, 32'd0);
    chk("R6 cap_ready after init", {31'd0, cap_ready_o}, 32'd1);

    // Vector table: capture reads in every format, past the sample end.
    for (int v = 0; v < 6; v++) begin
      logic [73:0] e;
      int lastb;
      e = CAP_VEC[v];
      fmt_stereo_i = e[73];
      fmt_wide_i = e[72];
      lastb = (e[73] && e[72]) ? 3 : ((e[73] || e[72]) ? 1 : 0);
      push_cap(e[71:40]);
      for (int j = 0; j < 5; j++) begin
        settle();
        chk("R10 cap_next before read", {30'd0, cap_next_o},
            (j < lastb) ? 32'(j) : 32'(lastb));
        host_read(2'd3, "R4 R5 capture byte", e[39 - 8*j -: 8]);
      end
    end

    // Same-cycle capture handshake and read.
    fmt_stereo_i = 1'b1;
    fmt_wide_i = 1'b1;
    push_cap(32'h11223344);
    host_read(2'd3, "R5 byte0", 8'h44);
    host_read(2'd3, "R5 byte1", 8'h33);
    @(negedge clk);
    cap_data_i = 32'h55667788;
    cap_valid_i = 1'b1;
    host_addr_i = 2'd3;
    host_rd_i = 1'b1;
    #1 chk("R6 read beside handshake returns old byte", {24'd0, host_rdata_o}, 32'h22);
    @(posedge clk);
    #1 begin cap_valid_i = 1'b0; host_rd_i = 1'b0; end
    settle();
    chk("R6 pointer restarts", {30'd0, cap_next_o}, 32'd0);
    host_read(2'd3, "R6 new word byte0", 8'h88);

    host_read(2'd1, "R1 other address reads zero", 8'h00);
    settle();
    chk("R1 other address read keeps pointer", {30'd0, cap_next_o}, 32'd1);

    // Playback stereo 16-bit.
    host_write(2'd3, 8'h01);
    settle();
    chk("R10 pb_next after one write", {30'd0, pb_next_o}, 32'd1);
    host_write(2'd3, 8'h02);
    host_write(2'd3, 8'h03);
    settle();
    chk("R7 not valid before last byte", {31'd0, pb_valid_o}, 32'd0);
    host_write(2'd3, 8'h04);
    settle();
    chk("R7 valid after last byte", {31'd0, pb_valid_o}, 32'd1);
    chk("R7 stereo16 word", pb_data_o, 32'h04030201);
    host_write(2'd3, 8'hFF);
    settle();
    chk("R8 extra write dropped", pb_data_o, 32'h04030201);
    chk("R8 valid held", {31'd0, pb_valid_o}, 32'd1);
    pb_take();
    settle();
    chk("R9 valid cleared", {31'd0, pb_valid_o}, 32'd0);
    chk("R9 pointer restarts", {30'd0, pb_next_o}, 32'd0);
    chk("R9 word cleared", pb_data_o, 32'd0);

    // Mono 8-bit playback.
    fmt_stereo_i = 1'b0;
    fmt_wide_i = 1'b0;
    host_write(2'd2, 8'h77);
    settle();
    chk("R1 other address write ignored", {30'd0, pb_next_o}, 32'd0);
    host_write(2'd3, 8'h5A);
    settle();
    chk("R4 R7 mono8 word", {pb_valid_o, pb_data_o[30:0]}, {1'b1, 31'h0000005A});
    pb_take();

    // Stereo 8-bit playback.
    fmt_stereo_i = 1'b1;
    host_write(2'd3, 8'h11);
    host_write(2'd3, 8'h22);
    settle();
    chk("R4 R7 stereo8 word", pb_data_o, 32'h00220011);
    chk("R7 stereo8 valid", {31'd0, pb_valid_o}, 32'd1);
    pb_take();

    // Mono 16-bit playback.
    fmt_stereo_i = 1'b0;
    fmt_wide_i = 1'b1;
    host_write(2'd3, 8'hCD);
    host_write(2'd3, 8'hAB);
    settle();
    chk("R4 R7 mono16 word", pb_data_o, 32'h0000ABCD);
    pb_take();

    // Reset again returns to initialisation.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    settle();
    chk("R2 reset re-enters init", {31'd0, init_o}, 32'd1);
    host_read(2'd3, "R2 fill byte after reset", 8'h80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule